// File: doc/BRIEF.md
# Dual-Rank Termination Control Generator

This block sits beside the command path of a DDR3-style controller that drives two ranks through a two-bit chip select. Each read or write command is offered on a valid/ready port together with its direction and target rank. After a fixed latency, the block raises the on-die-termination pin of every rank that has to terminate. The pin then stays high for the length of the data burst. A write turns termination on at both ranks. A read turns it on only at the rank that is not being read.

Alongside the pins, the block reports the termination each rank actually applies. The value depends on three things: the two shared settings (nominal termination and dynamic write termination, each on or off), whether the rank is the target of the access or is standing by, and whether the access is a read or a write. A command flows in only one direction. The port never applies back-pressure: `cmd_ready` is held high out of reset, and every cycle with `cmd_valid` high is one accepted command.

Top module: `ddr_odt_gen`

## Requirements
- R1: A write accepted on clock edge k raises both `odt` bits for exactly BURST_CYC cycles, beginning with the cycle that follows edge k+ODT_LAT (defaults: ODT_LAT=2, BURST_CYC=4).
- R2: A read from rank N accepted on edge k raises `odt[1-N]` over that same window. `odt[N]` stays low unless a write window covers rank N.
- R3: While a rank is inside the window of a write aimed at it, its 2-bit field `term_eff[2r+1:2r]` reads 2'b10 (write termination) when `cfg_wr_en` is 1. Otherwise it reads 2'b01 (nominal) when `cfg_nom_en` is 1, and 2'b00 (off) when neither is set.
- R4: While a rank is inside the window of a read aimed at it, and no write aimed at it overlaps, its field reads 2'b00 whatever the settings.
- R5: A rank that is not the target of any window reads 2'b01 when `cfg_nom_en` is 1 and 2'b00 otherwise. This holds when the other rank is being read, when it is being written, and when the block is idle. The code 2'b11 never appears.
- R6: With no command in flight, `odt` is 2'b00.
- R7: Windows from back-to-back or closely spaced commands merge, so a bit stays high with no gap until the last window ends. When a write window and a read window aimed at the same rank overlap, that rank follows the write rule.
- R8: A synchronous active-high `rst` discards every pending command and window, so `odt` reads 2'b00 from the first cycle after the reset edge.
- R9: `cmd_ready` is 1 in every cycle outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_rank | input | 1 | Target rank of the command |
| cfg_nom_en | input | 1 | Nominal termination enabled (shared by both ranks) |
| cfg_wr_en | input | 1 | Dynamic write termination enabled (shared by both ranks) |
| odt | output | 2 | Termination pin per rank, bit r for rank r |
| term_eff | output | 4 | Applied termination, 2 bits per rank: 00 off, 01 nominal, 10 write |

## Verification
The bench goes after the start and end cycles of each window. A design that miscounts the latency or the burst shifts a pin by one cycle, and the per-cycle comparison catches that. It sends a read to each rank. A design that terminates the rank being read, or copies the write rule to reads, shows a high bit where it should be low. All four setting combinations are applied to written, read and idle ranks, so a swapped precedence between write and nominal termination, or a standby rank that takes the write value, gives a wrong code. Back-to-back commands and a write overlapping a read on the same rank expose gaps between windows and a lost write precedence. A reset in the middle of a window catches pending state that survives the reset.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    TERM_OFF = 2'b00,
    TERM_NOM = 2'b01,
    TERM_WR  = 2'b10
  } term_e;

  typedef struct packed {
    logic vld;
    logic wr;
    logic rank;
  } odt_cmd_t;
endpackage

// File: rtl/odt_cmd_delay.sv
module odt_cmd_delay
  import odt_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  odt_cmd_t in_cmd,
  output odt_cmd_t out_cmd
);
  localparam int STAGES = (DEPTH < 1) ? 1 : DEPTH;

  odt_cmd_t stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= in_cmd;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else     stage[i] <= stage[i-1];
    end
  end

  assign out_cmd = stage[STAGES-1];
endmodule

// File: rtl/odt_rank_window.sv
module odt_rank_window
  import odt_pkg::*;
#(
  parameter int BURST_CYC = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ld_wr_self,
  input  logic  ld_rd_self,
  input  logic  ld_other,
  input  logic  cfg_nom_en,
  input  logic  cfg_wr_en,
  output logic  odt_o,
  output term_e term_o
);
  localparam int CW = $clog2(BURST_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(BURST_CYC);

  logic [CW-1:0] wself_cnt, rself_cnt, other_cnt;

  // Each window restarts at full length on a new load, which merges overlaps
  always_ff @(posedge clk) begin
    if (rst) begin
      wself_cnt <= '0;
      rself_cnt <= '0;
      other_cnt <= '0;
    end else begin
      wself_cnt <= ld_wr_self ? FULL : (wself_cnt != 0 ? wself_cnt - 1'b1 : '0);
      rself_cnt <= ld_rd_self ? FULL : (rself_cnt != 0 ? rself_cnt - 1'b1 : '0);
      other_cnt <= ld_other   ? FULL : (other_cnt != 0 ? other_cnt - 1'b1 : '0);
    end
  end

  logic wself_on, rself_on, other_on;
  assign wself_on = (wself_cnt != 0);
  assign rself_on = (rself_cnt != 0);
  assign other_on = (other_cnt != 0);

  assign odt_o = wself_on | other_on;

  always_comb begin
    if (wself_on)      term_o = cfg_wr_en ? TERM_WR : (cfg_nom_en ? TERM_NOM : TERM_OFF);
    else if (rself_on) term_o = TERM_OFF;
    else               term_o = cfg_nom_en ? TERM_NOM : TERM_OFF;
  end

  // R1: a pin only rises on the cycle after a window load
  assert_odt_start_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(odt_o) |-> $past(ld_wr_self | ld_other));
  // R3: write code requires the write setting
  assert_wr_code_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    (term_o == TERM_WR) |-> cfg_wr_en);
  // R5: illegal code never produced
  assert_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
    term_o != 2'b11);
  // R4: a rank read without a write on itself never terminates
  assert_read_self_off_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(ld_rd_self) && !wself_on) |-> term_o == TERM_OFF);
endmodule

// File: rtl/ddr_odt_gen.sv
module ddr_odt_gen
  import odt_pkg::*;
#(
  parameter int ODT_LAT   = 2,
  parameter int BURST_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_write,
  input  logic       cmd_rank,
  input  logic       cfg_nom_en,
  input  logic       cfg_wr_en,
  output logic [1:0] odt,
  output logic [3:0] term_eff
);
  localparam int RANKS = 2;

  logic     ready_q;
  odt_cmd_t cmd_in, cmd_due;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign cmd_ready = ready_q;

  assign cmd_in = '{vld: cmd_valid & ready_q, wr: cmd_write, rank: cmd_rank};

  odt_cmd_delay #(.DEPTH(ODT_LAT)) u_delay (
    .clk     (clk),
    .rst     (rst),
    .in_cmd  (cmd_in),
    .out_cmd (cmd_due)
  );

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    logic  hit;
    term_e term_r;
    assign hit = (cmd_due.rank == 1'(r));

    odt_rank_window #(.BURST_CYC(BURST_CYC)) u_win (
      .clk        (clk),
      .rst        (rst),
      .ld_wr_self (cmd_due.vld &  cmd_due.wr & hit),
      .ld_rd_self (cmd_due.vld & ~cmd_due.wr & hit),
      .ld_other   (cmd_due.vld & ~hit),
      .cfg_nom_en (cfg_nom_en),
      .cfg_wr_en  (cfg_wr_en),
      .odt_o      (odt[r]),
      .term_o     (term_r)
    );
    assign term_eff[2*r +: 2] = term_r;
  end

  // R8: reset leaves both pins low
  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> odt == 2'b00);
  // R9: never back-pressures outside reset
  assert_ready_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cmd_ready);
  // R6: pins low implies both ranks at standby code
  assert_idle_standby_R6: assert property (@(posedge clk) disable iff (rst)
    (odt == 2'b00 && $past(odt) == 2'b00 && !cmd_due.vld) |->
      $countones(term_eff) <= 2);
endmodule

// File: tb/ddr_odt_gen_test.sv
module ddr_odt_gen_test;
  localparam int LAT = 2;
  localparam int BL  = 4;
  localparam int NC  = 2048;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_write = 0, cmd_rank = 0;
  logic cfg_nom_en = 0, cfg_wr_en = 0;
  logic cmd_ready;
  logic [1:0] odt;
  logic [3:0] term_eff;

  int errors = 0, checks = 0, cyc = 0;
  bit chk_en = 0;
  bit ws [2][NC];
  bit rs [2][NC];
  bit os [2][NC];

  ddr_odt_gen #(.ODT_LAT(LAT), .BURST_CYC(BL)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_rank(cmd_rank), .cfg_nom_en(cfg_nom_en),
    .cfg_wr_en(cfg_wr_en), .odt(odt), .term_eff(term_eff)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic clear_sb();
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < NC; i++) begin
        ws[r][i] = 0; rs[r][i] = 0; os[r][i] = 0;
      end
  endtask

  // Driver: called at a negedge; pushes expected windows into the scoreboard
  task automatic issue(bit wr, bit rk);
    cmd_valid = 1; cmd_write = wr; cmd_rank = rk;
    for (int i = cyc + 1 + LAT; i <= cyc + LAT + BL; i++)
      for (int r = 0; r < 2; r++) begin
        if (r == rk) begin
          if (wr) ws[r][i] = 1; else rs[r][i] = 1;
        end else os[r][i] = 1;
      end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_term(int r, int i);
    if (ws[r][i]) return cfg_wr_en ? 2 : (cfg_nom_en ? 1 : 0);
    if (rs[r][i]) return 0;
    return cfg_nom_en ? 1 : 0;
  endfunction

  // Monitor: compares each cycle against the scoreboard
  always @(negedge clk) begin
    if (chk_en && cyc < NC) begin
      int eo;
      eo = 0;
      for (int r = 0; r < 2; r++)
        if (ws[r][cyc] || os[r][cyc]) eo |= (1 << r);
      check("R1/R2/R6/R7 odt", odt, eo);
      for (int r = 0; r < 2; r++)
        check("R3/R4/R5 term_eff", term_eff[2*r +: 2], exp_term(r, cyc));
      check("R9 ready", cmd_ready, 1);
    end
  end

  initial begin
    clear_sb();
    repeat (3) @(negedge clk);
    check("R8 reset odt", odt, 0);
    rst = 0;
    @(negedge clk);
    chk_en = 1;
    idle(2);
    for (int c = 0; c < 4; c++) begin
      cfg_nom_en = c[0]; cfg_wr_en = c[1];
      idle(2);
      issue(1, 0); idle(8);   // R1 write rank 0
      issue(1, 1); idle(8);   // R3 write rank 1
      issue(0, 0); idle(8);   // R2/R4 read rank 0
      issue(0, 1); idle(8);   // R2/R5 read rank 1
      issue(1, 0); issue(1, 0); idle(8);          // R7 merge
      issue(0, 1); issue(1, 1); idle(8);          // R7 write precedence
      issue(1, 0); idle(2); issue(0, 0); idle(8); // R7 write then read same rank
    end
    // R8: reset in the middle of a window
    cfg_nom_en = 1; cfg_wr_en = 1;
    issue(1, 1); idle(LAT + 1);
    chk_en = 0;
    rst = 1; @(negedge clk);
    check("R8 odt after reset edge", odt, 0);
    rst = 0; clear_sb();
    @(negedge clk);
    chk_en = 1;
    idle(10);
    issue(0, 0); idle(8);
    chk_en = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule